// File: doc/BRIEF.md
# Carry-State Prefix Adder

This block adds two N-bit operands and a carry-in. The sum arrives a fixed number of cycles later, together with the carry-out. First, every bit position is labelled with one of three carry states, according to its two operand bits. Next, a recursive-doubling prefix over those labels settles the carry into every position in log2(N) steps. Last, each sum bit is formed as the exclusive-or of its two operand bits and its settled carry.

The prefix steps are registered and never stall, so the block accepts a new operation on every clock. A `start` pulse presents an operation. The matching `done` pulse, with its `sum_out` and `carry_out`, appears exactly log2(N)+1 cycles later. Operations issued on consecutive cycles come out in the same order on consecutive cycles. N must be a power of two of at least 2.

Top module: `csp_adder`

## Requirements
- R1: Each bit position is labelled stop when both operand bits are 0, generate when both are 1, and propagate when they differ. The 2-bit codes are stop = 00, propagate = 01, generate = 11, and code 10 never occurs. Operands of all zeros give sum 0 with carry-out 0. Operands of all ones give sum of all ones except bit 0, with carry-out 1.
- R2: The carry-in is folded into bit 0 before the prefix starts. If bit 0 is propagate, its state becomes generate when carry_in is 1 and stop when carry_in is 0. After the last prefix step, no position is left in the propagate state. For example, all-ones plus 0 with carry_in 1 gives sum 0 and carry-out 1.
- R3: The combine step takes the state of the higher position, unless that state is propagate, in which case it takes the state of the lower position. A carry can therefore travel through any run of propagate positions. For example, 0x7FFF + 0x0001 at N=16 gives 0x8000.
- R4: In the step with distance d, a position i with i < d keeps its state unchanged, so carries formed in the low bits are still correct.
- R5: sum_out equals (a_in + b_in + carry_in) modulo 2^N for any operands.
- R6: carry_out equals bit N of the full sum a_in + b_in + carry_in.
- R7: done is high for exactly one cycle, log2(N)+1 clock cycles after the cycle in which start is sampled high. sum_out and carry_out are valid in that cycle.
- R8: Starts issued on consecutive cycles each produce their own result, in order, on consecutive cycles. Later changes of the operands do not affect a result that is already in flight.
- R9: While rst is high, done is low in the following cycle. Operations in flight, and a start that arrives together with rst, produce no done.
- R10: done stays low in every cycle that does not correspond to an earlier start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Presents a_in, b_in and carry_in for one addition |
| a_in | input | N | First operand |
| b_in | input | N | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum_out | output | N | Registered sum, valid while done is high |
| carry_out | output | 1 | Registered carry out of bit N-1, valid while done is high |
| done | output | 1 | One-cycle pulse marking a valid result |

## Verification
A corrupted carry state in any prefix stage shows up at the ports as a wrong sum bit. That bit sits at or above the corrupted position, or the fault appears as a wrong carry-out. It becomes visible in the done cycle of that same operation, log2(N)+1 cycles after its start. A fault in the valid pipeline instead shifts, drops or duplicates done pulses, so the bench compares done in every single cycle, and not only when a result is expected. Directed operands place long propagate runs, carries at the top bit, and carries at the lowest bit, because each of these exercises a different step distance.

// File: rtl/csp_pkg.sv
package csp_pkg;

  typedef enum logic [1:0] {
    CS_STOP = 2'b00,
    CS_PROP = 2'b01,
    CS_GEN  = 2'b11
  } cstate_e;

  // Higher position wins unless it only passes its incoming carry along.
  function automatic cstate_e cs_merge(input cstate_e lo, input cstate_e hi);
    return (hi == CS_PROP) ? lo : hi;
  endfunction

  // A settled state carries out only when it generates.
  function automatic logic cs_carry(input cstate_e s);
    return (s == CS_GEN);
  endfunction

endpackage

// File: rtl/csp_classify.sv
module csp_classify
  import csp_pkg::*;
#(
  parameter int N = 16
) (
  input  logic [N-1:0]      a,
  input  logic [N-1:0]      b,
  input  logic              cin,
  output logic [N-1:0][1:0] st,
  output logic [N-1:0]      hs
);

  assign hs = a ^ b;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      if (hs[i])     st[i] = CS_PROP;
      else if (a[i]) st[i] = CS_GEN;
      else           st[i] = CS_STOP;
    end
    // carry-in absorbed into the lowest position
    if (hs[0]) st[0] = cin ? CS_GEN : CS_STOP;
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      if (!$isunknown(st[i])) begin
        // R1
        rsvd_code_chk: assert (st[i] != 2'b10);
      end
    end
  end

endmodule

// File: rtl/csp_prefix_step.sv
module csp_prefix_step
  import csp_pkg::*;
#(
  parameter int N    = 16,
  parameter int DIST = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_v,
  input  logic [N-1:0][1:0] in_st,
  input  logic [N-1:0]      in_hs,
  input  logic              in_cin,
  output logic              out_v,
  output logic [N-1:0][1:0] out_st,
  output logic [N-1:0]      out_hs,
  output logic              out_cin
);

  logic [N-1:0][1:0] nxt;

  for (genvar i = 0; i < N; i++) begin : g_pos
    if (i >= DIST) begin : g_merge
      assign nxt[i] = cs_merge(cstate_e'(in_st[i-DIST]), cstate_e'(in_st[i]));
    end else begin : g_hold
      assign nxt[i] = in_st[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) out_v <= 1'b0;
    else     out_v <= in_v;
  end

  always_ff @(posedge clk) begin
    out_st  <= nxt;
    out_hs  <= in_hs;
    out_cin <= in_cin;
  end

  // R4
  low_hold_chk: assert property (@(posedge clk) disable iff (rst)
    in_v |=> out_st[DIST-1:0] == $past(in_st[DIST-1:0]));

  // R3
  top_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (in_v && in_st[N-1] != CS_PROP) |=> out_st[N-1] == $past(in_st[N-1]));

  // R1
  step_code_chk: assert property (@(posedge clk) disable iff (rst)
    out_v |-> out_st[N-1] != 2'b10);

endmodule

// File: rtl/csp_sum_form.sv
module csp_sum_form
  import csp_pkg::*;
#(
  parameter int N = 16
) (
  input  logic [N-1:0][1:0] st,
  input  logic [N-1:0]      hs,
  input  logic              cin,
  output logic [N-1:0]      sum,
  output logic              cout
);

  logic [N-1:0] cy;

  for (genvar i = 0; i < N; i++) begin : g_bit
    if (i == 0) begin : g_first
      assign cy[i] = cin;
    end else begin : g_rest
      assign cy[i] = cs_carry(cstate_e'(st[i-1]));
    end
    assign sum[i] = hs[i] ^ cy[i];
  end

  assign cout = cs_carry(cstate_e'(st[N-1]));

endmodule

// File: rtl/csp_adder.sv
module csp_adder
  import csp_pkg::*;
#(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [N-1:0] a_in,
  input  logic [N-1:0] b_in,
  input  logic         carry_in,
  output logic [N-1:0] sum_out,
  output logic         carry_out,
  output logic         done
);

  localparam int L   = $clog2(N);
  localparam int LAT = L + 1;

  logic              vs   [L+1];
  logic [N-1:0][1:0] sts  [L+1];
  logic [N-1:0]      hss  [L+1];
  logic              cins [L+1];

  csp_classify #(.N(N)) u_class (
    .a   (a_in),
    .b   (b_in),
    .cin (carry_in),
    .st  (sts[0]),
    .hs  (hss[0])
  );

  assign vs[0]   = start;
  assign cins[0] = carry_in;

  for (genvar k = 0; k < L; k++) begin : g_step
    csp_prefix_step #(.N(N), .DIST(1 << k)) u_step (
      .clk     (clk),
      .rst     (rst),
      .in_v    (vs[k]),
      .in_st   (sts[k]),
      .in_hs   (hss[k]),
      .in_cin  (cins[k]),
      .out_v   (vs[k+1]),
      .out_st  (sts[k+1]),
      .out_hs  (hss[k+1]),
      .out_cin (cins[k+1])
    );
  end

  logic [N-1:0] sum_c;
  logic         cout_c;

  csp_sum_form #(.N(N)) u_sum (
    .st   (sts[L]),
    .hs   (hss[L]),
    .cin  (cins[L]),
    .sum  (sum_c),
    .cout (cout_c)
  );

  always_ff @(posedge clk) begin
    if (rst) done <= 1'b0;
    else     done <= vs[L];
  end

  always_ff @(posedge clk) begin
    sum_out   <= sum_c;
    carry_out <= cout_c;
  end

  function automatic logic any_prop(input logic [N-1:0][1:0] s);
    logic f;
    f = 1'b0;
    for (int i = 0; i < N; i++) f |= (s[i] == CS_PROP);
    return f;
  endfunction

  // R2
  settled_chk: assert property (@(posedge clk) disable iff (rst)
    vs[L] |-> !any_prop(sts[L]));

  // R7
  done_lat_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(start, LAT));

  // R9
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !done);

endmodule

// File: tb/tb_csp_adder.sv
module tb_csp_adder;

  localparam int N   = 16;
  localparam int LAT = $clog2(N) + 1;
  localparam int SL  = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic         cin = 1'b0;
  logic [N-1:0] a = '0;
  logic [N-1:0] b = '0;
  logic [N-1:0] sum_out;
  logic         carry_out;
  logic         done;

  csp_adder #(.N(N)) dut (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .a_in      (a),
    .b_in      (b),
    .carry_in  (cin),
    .sum_out   (sum_out),
    .carry_out (carry_out),
    .done      (done)
  );

  always #5 clk = ~clk;

  int    total = 0;
  int    bad   = 0;
  int    cyc   = 0;
  string idle_tag = "R10";

  bit           exp_v [SL];
  logic [N-1:0] exp_s [SL];
  logic         exp_c [SL];
  string        exp_t [SL];

  function automatic logic [N:0] ref_add(input logic [N-1:0] x, input logic [N-1:0] y,
                                         input logic ci);
    return {1'b0, x} + {1'b0, y} + {{N{1'b0}}, ci};
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] ex);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, ex);
    end
  endtask

  // Called at a falling edge: check this cycle's outputs, then drive the next inputs.
  task automatic tick(input bit s, input bit r, input logic [N-1:0] av,
                      input logic [N-1:0] bv, input bit ci, input string tag);
    int idx;
    logic [N:0] full;
    idx = cyc % SL;
    chk(done == exp_v[idx], exp_v[idx] ? "R7" : idle_tag, "done",
        64'(done), 64'(exp_v[idx]));
    if (exp_v[idx] && done) begin
      chk(sum_out == exp_s[idx], exp_t[idx], "sum", 64'(sum_out), 64'(exp_s[idx]));
      chk(carry_out == exp_c[idx], exp_t[idx] == "R5" ? "R6" : exp_t[idx], "carry",
          64'(carry_out), 64'(exp_c[idx]));
    end
    exp_v[idx] = 1'b0;
    rst = r; start = s; a = av; b = bv; cin = ci;
    if (r) begin
      for (int j = 0; j < SL; j++) exp_v[j] = 1'b0;
    end else if (s) begin
      full = ref_add(av, bv, ci);
      idx = (cyc + LAT) % SL;
      exp_v[idx] = 1'b1;
      exp_s[idx] = full[N-1:0];
      exp_c[idx] = full[N];
      exp_t[idx] = tag;
    end
    @(negedge clk);
    cyc++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(1'b0, 1'b0, N'($urandom), N'($urandom), 1'b0, "R10");
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int j = 0; j < SL; j++) exp_v[j] = 1'b0;
    @(negedge clk);
    idle_tag = "R9";
    for (int i = 0; i < 3; i++) tick(1'b0, 1'b1, '0, '0, 1'b0, "R9");
    idle_tag = "R10";
    idle(2);

    // directed corner cases
    tick(1'b1, 1'b0, '0, '0, 1'b0, "R1");
    tick(1'b1, 1'b0, '1, '1, 1'b0, "R1");
    tick(1'b1, 1'b0, '1, '0, 1'b1, "R2");
    tick(1'b1, 1'b0, 16'h5555, 16'hAAAA, 1'b1, "R2");
    tick(1'b1, 1'b0, 16'h5555, 16'hAAAA, 1'b0, "R3");
    tick(1'b1, 1'b0, 16'h7FFF, 16'h0001, 1'b0, "R3");
    tick(1'b1, 1'b0, 16'h0001, 16'h0001, 1'b0, "R4");
    tick(1'b1, 1'b0, 16'h0002, 16'h0001, 1'b1, "R4");
    tick(1'b1, 1'b0, 16'h8000, 16'h8000, 1'b0, "R6");
    tick(1'b1, 1'b0, 16'hFFFF, 16'h0001, 1'b0, "R6");
    idle(LAT + 2);

    // reset flushes work in flight and ignores a start that comes with it
    tick(1'b1, 1'b0, 16'h1234, 16'h4321, 1'b0, "R9");
    tick(1'b1, 1'b0, 16'hFFFF, 16'hFFFF, 1'b1, "R9");
    tick(1'b1, 1'b1, 16'h0F0F, 16'hF0F0, 1'b1, "R9");
    idle_tag = "R9";
    idle(LAT + 2);
    idle_tag = "R10";

    // back-to-back stream with operands changing every cycle
    for (int i = 0; i < 300; i++)
      tick(1'b1, 1'b0, N'($urandom), N'($urandom), 1'($urandom), "R8");

    // random mix of idle and busy cycles
    for (int i = 0; i < 2000; i++)
      tick(($urandom % 4) != 0, 1'b0, N'($urandom), N'($urandom), 1'($urandom), "R5");
    idle(LAT + 3);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog R7 actual=%0d expected=%0d", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule